// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides which external priority level, if any, should be presented to a processor core as a hard interrupt request. It merges sixteen external level lines with a software interrupt register. It then compares the merged vector against the core's current interrupt priority mask. It outputs one request line, together with the trap type of the winning level. Two timer bits inside the software register do not stand for levels of their own. Instead, either of them raises level 14.

The software register lives inside the block. It is updated through a two-bit operation code and a data word. The supported operations are OR-in, bit-clear, and full replace. The result of an operation is seen by the resolver at the same clock edge that stores it.

The core supplies several status inputs: a global interrupt enable, a flag saying a vectored interrupt is waiting, and the current trap level with the trap type stored at that level. The vectored flag freezes the outputs, because vectored interrupts outrank every level. A level interrupt that is already being serviced with a higher trap type keeps a new, lower one from being raised. All pins are plain control and status signals. Nothing at the edge of the block carries a data stream, so there is no valid/ready handshake and no back-pressure: every input is sampled on every rising clock edge.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset (active-low `rst_n`), `irq_req` is 0, `irq_tt` is 0 and `sw_value` is 0.
- R2: `sw_op` selects the software register update at the next rising edge: 2'b00 keeps it, 2'b01 ORs in `sw_data`, 2'b10 clears the bits set in `sw_data`, 2'b11 replaces it with `sw_data`; `sw_value` shows the stored register.
- R3: The pending level vector is `ext_level` ORed with the software register, where software bit i stands for level i, except software bits 0 and 16 (the timer bits), which never join the OR; external bit 0 alone never produces a request.
- R4: When software bit 0 or software bit 16 is set, level 14 counts as pending.
- R5: With interrupts enabled and no vectored interrupt waiting, the highest pending level L above `cur_pil` is selected, and at the next rising edge `irq_req` is 1 and `irq_tt` is 0x40 | L (range 0x41 to 0x4F). A software operation and its result reach the outputs at the same edge.
- R6: When the pending vector, read as a number, is below 2 << `cur_pil` (no level above the mask), `irq_req` and `irq_tt` go to 0 at the next edge.
- R7: When `int_en` is 0 and no vectored interrupt is waiting, `irq_req` and `irq_tt` go to 0 at the next edge.
- R8: While `vec_pending` is 1, `irq_req` and `irq_tt` keep their values whatever the other inputs do.
- R9: When `trap_lvl` is nonzero, `trap_tt_cur[8:4]` equals 5'h04 and `trap_tt_cur` is greater than the newly selected trap type, the outputs keep their previous values.
- R10: A stored trap type outside 0x40 to 0x4F, or `trap_lvl` equal to 0, never stops a new level from being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_level | input | 16 | External interrupt level lines, bit i = level i |
| sw_op | input | 2 | Software register operation code |
| sw_data | input | 17 | Operand for the software register operation |
| cur_pil | input | 4 | Current processor interrupt priority level |
| int_en | input | 1 | Global interrupt enable |
| vec_pending | input | 1 | A vectored interrupt is waiting |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_tt_cur | input | 9 | Trap type stored at the current trap level |
| sw_value | output | 17 | Current software interrupt register contents |
| irq_req | output | 1 | Hard interrupt request |
| irq_tt | output | 9 | Trap type of the requested level, 0 when idle |

## Verification
The hardest case to reach is the suppression hold. It needs a request that is already standing. Then the trap context must name a level interrupt whose type is higher than a newly pending level, while that same level would change the index if nothing stopped it. The stimulus first raises level 5 with no trap context. It then loads trap level 1 with stored type 0x4A and adds level 7, so the output must stay at 0x45. After that it adds level 12 to show that a higher level gets through, and finally drops the trap level or moves the stored type out of the group to show that the block resolves normally again.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  localparam int unsigned DEF_LEVELS    = 16;
  localparam int unsigned DEF_TT_W      = 9;
  localparam int unsigned DEF_TL_W      = 3;
  localparam int unsigned DEF_SW_W      = 17;
  localparam int unsigned DEF_TICK_BIT  = 0;
  localparam int unsigned DEF_STICK_BIT = 16;
  localparam int unsigned DEF_TIMER_LVL = 14;
  localparam logic [DEF_TT_W-1:0] DEF_TT_BASE = 9'h040;

  typedef enum logic [1:0] {
    SW_HOLD  = 2'b00,
    SW_OR    = 2'b01,
    SW_CLEAR = 2'b10,
    SW_LOAD  = 2'b11
  } sw_op_e;

endpackage

// File: rtl/irq_softint_reg.sv
module irq_softint_reg
  import irq_res_pkg::*;
#(
  parameter int unsigned SW_W = DEF_SW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op,
  input  logic [SW_W-1:0] data,
  output logic [SW_W-1:0] sw_q,
  output logic [SW_W-1:0] sw_nxt
);

  sw_op_e op_e;
  assign op_e = sw_op_e'(op);

  always_comb begin
    unique case (op_e)
      SW_OR:    sw_nxt = sw_q | data;
      SW_CLEAR: sw_nxt = sw_q & ~data;
      SW_LOAD:  sw_nxt = data;
      default:  sw_nxt = sw_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_nxt;
  end

  // R2: each operation lands in the register one edge later
  a_r2_sw_or: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b01) |=> (sw_q == ($past(sw_q) | $past(data))));
  a_r2_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b10) |=> (sw_q == ($past(sw_q) & ~$past(data))));
  a_r2_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b11) |=> (sw_q == $past(data)));
  a_r2_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b00) |=> $stable(sw_q));

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_LEVELS,
  parameter int unsigned SW_W       = DEF_SW_W,
  parameter int unsigned TICK_BIT   = DEF_TICK_BIT,
  parameter int unsigned STICK_BIT  = DEF_STICK_BIT,
  parameter int unsigned TIMER_LVL  = DEF_TIMER_LVL
) (
  input  logic [NUM_LEVELS-1:0] ext_level,
  input  logic [SW_W-1:0]       sw,
  output logic [NUM_LEVELS-1:0] pend
);

  logic timer_hit;
  assign timer_hit = sw[TICK_BIT] | sw[STICK_BIT];

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    logic sw_part;
    if (i == TICK_BIT || i == STICK_BIT) begin : g_timer_bit
      assign sw_part = 1'b0;
    end else begin : g_plain_bit
      assign sw_part = sw[i];
    end
    if (i == TIMER_LVL) begin : g_timer_lvl
      assign pend[i] = ext_level[i] | sw_part | timer_hit;
    end else begin : g_other_lvl
      assign pend[i] = ext_level[i] | sw_part;
    end
  end

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_LEVELS,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] pend,
  input  logic [LVL_W-1:0]      pil,
  output logic                  none_above,
  output logic [LVL_W-1:0]      top_lvl
);

  logic [NUM_LEVELS:0]   thresh;
  logic [NUM_LEVELS-1:0] above;

  assign thresh     = (NUM_LEVELS+1)'(2) << pil;
  assign none_above = ({1'b0, pend} < thresh);

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_mask
    assign above[i] = pend[i] & (LVL_W'(i) > pil);
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (above[i]) top_lvl = LVL_W'(i);
    end
  end

  // R6: numeric threshold test and the bitwise mask must agree
  a_r6_threshold_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    none_above == (above == '0));
  // R5: the chosen level is above the mask whenever something is pending
  a_r5_top_above_pil: assert property (@(posedge clk) disable iff (!rst_n)
    !none_above |-> (top_lvl > pil));

endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_LEVELS     = DEF_LEVELS,
  parameter int unsigned TT_W           = DEF_TT_W,
  parameter int unsigned TL_W           = DEF_TL_W,
  parameter logic [TT_W-1:0] TT_BASE    = DEF_TT_BASE,
  localparam int unsigned LVL_W         = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             none_above,
  input  logic [LVL_W-1:0] top_lvl,
  input  logic             int_en,
  input  logic             vec_pending,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  trap_tt_cur,
  output logic             req_q,
  output logic [TT_W-1:0]  tt_q
);

  logic [TT_W-1:0] new_tt;
  logic            in_group;
  logic            suppress;
  logic            req_n;
  logic [TT_W-1:0] tt_n;

  assign new_tt   = TT_BASE | TT_W'(top_lvl);
  assign in_group = (trap_tt_cur[TT_W-1:LVL_W] == TT_BASE[TT_W-1:LVL_W]);
  assign suppress = (trap_lvl != '0) && in_group && (trap_tt_cur > new_tt);

  always_comb begin
    req_n = req_q;
    tt_n  = tt_q;
    if (!vec_pending) begin
      if (none_above || !int_en) begin
        req_n = 1'b0;
        tt_n  = '0;
      end else if (!suppress && (new_tt != tt_q)) begin
        req_n = 1'b1;
        tt_n  = new_tt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else begin
      req_q <= req_n;
      tt_q  <= tt_n;
    end
  end

  // R1: an idle request line always carries a cleared trap type
  a_r1_idle_tt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (tt_q == '0));
  // R5: a raised request carries a level type in the external group
  a_r5_tt_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ((tt_q[TT_W-1:LVL_W] == TT_BASE[TT_W-1:LVL_W]) && (tt_q[LVL_W-1:0] != '0)));
  // R8: a waiting vectored interrupt freezes the outputs
  a_r8_vec_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pending |=> ($stable(req_q) && $stable(tt_q)));
  // R7: disabling withdraws the request
  a_r7_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !vec_pending) |=> !req_q);
  // R9: a higher serviced level keeps the outputs unchanged
  a_r9_suppress_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && !vec_pending && !none_above && suppress) |=> ($stable(req_q) && $stable(tt_q)));

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_LEVELS  = DEF_LEVELS,
  parameter int unsigned TT_W        = DEF_TT_W,
  parameter int unsigned TL_W        = DEF_TL_W,
  parameter int unsigned SW_W        = DEF_SW_W,
  parameter int unsigned TICK_BIT    = DEF_TICK_BIT,
  parameter int unsigned STICK_BIT   = DEF_STICK_BIT,
  parameter int unsigned TIMER_LVL   = DEF_TIMER_LVL,
  parameter logic [TT_W-1:0] TT_BASE = DEF_TT_BASE,
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] ext_level,
  input  logic [1:0]            sw_op,
  input  logic [SW_W-1:0]       sw_data,
  input  logic [LVL_W-1:0]      cur_pil,
  input  logic                  int_en,
  input  logic                  vec_pending,
  input  logic [TL_W-1:0]       trap_lvl,
  input  logic [TT_W-1:0]       trap_tt_cur,
  output logic [SW_W-1:0]       sw_value,
  output logic                  irq_req,
  output logic [TT_W-1:0]       irq_tt
);

  logic [SW_W-1:0]       sw_nxt;
  logic [NUM_LEVELS-1:0] pend;
  logic                  none_above;
  logic [LVL_W-1:0]      top_lvl;

  irq_softint_reg #(.SW_W(SW_W)) u_swreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (sw_op),
    .data   (sw_data),
    .sw_q   (sw_value),
    .sw_nxt (sw_nxt)
  );

  irq_level_merge #(
    .NUM_LEVELS (NUM_LEVELS),
    .SW_W       (SW_W),
    .TICK_BIT   (TICK_BIT),
    .STICK_BIT  (STICK_BIT),
    .TIMER_LVL  (TIMER_LVL)
  ) u_merge (
    .ext_level (ext_level),
    .sw        (sw_nxt),
    .pend      (pend)
  );

  irq_prio_scan #(.NUM_LEVELS(NUM_LEVELS)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .pil        (cur_pil),
    .none_above (none_above),
    .top_lvl    (top_lvl)
  );

  irq_req_ctrl #(
    .NUM_LEVELS (NUM_LEVELS),
    .TT_W       (TT_W),
    .TL_W       (TL_W),
    .TT_BASE    (TT_BASE)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .none_above  (none_above),
    .top_lvl     (top_lvl),
    .int_en      (int_en),
    .vec_pending (vec_pending),
    .trap_lvl    (trap_lvl),
    .trap_tt_cur (trap_tt_cur),
    .req_q       (irq_req),
    .tt_q        (irq_tt)
  );

  // R4: a timer bit stored in the register means a request at or above level 14
  a_r4_timer_level: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && !vec_pending && (cur_pil < 4'd14) && trap_lvl == '0
     && (sw_nxt[TICK_BIT] || sw_nxt[STICK_BIT]))
    |=> (irq_req && irq_tt >= (TT_BASE | TT_W'(TIMER_LVL))));

endmodule

// File: tb/test_irq_level_resolver.sv
`timescale 1ns/1ps
module test_irq_level_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_level = '0;
  logic [1:0]  sw_op = 2'b00;
  logic [16:0] sw_data = '0;
  logic [3:0]  cur_pil = '0;
  logic        int_en = 1'b0;
  logic        vec_pending = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  trap_tt_cur = '0;
  logic [16:0] sw_value;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_level_resolver i_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .ext_level(ext_level), .sw_op(sw_op),
    .sw_data(sw_data), .cur_pil(cur_pil), .int_en(int_en),
    .vec_pending(vec_pending), .trap_lvl(trap_lvl), .trap_tt_cur(trap_tt_cur),
    .sw_value(sw_value), .irq_req(irq_req), .irq_tt(irq_tt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic req, input logic [8:0] tt);
    chk({tag, " req"}, 32'(irq_req), 32'(req));
    chk({tag, " tt"}, 32'(irq_tt), 32'(tt));
  endtask

  task automatic sw_do(input logic [1:0] op, input logic [16:0] d);
    sw_op = op; sw_data = d;
    tick();
    sw_op = 2'b00; sw_data = '0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 1'b0, 9'h000);
    chk("R1 reset sw", 32'(sw_value), 32'h0);
  endtask

  task automatic t_external();
    int_en = 1'b1; cur_pil = 4'd0;
    ext_level = 16'h0008; tick();
    expect_out("R5 level3", 1'b1, 9'h043);
    ext_level = 16'h0208; tick();
    expect_out("R5 level9", 1'b1, 9'h049);
    ext_level = 16'h8208; tick();
    expect_out("R5 level15", 1'b1, 9'h04F);
    ext_level = 16'h0001; tick();
    expect_out("R3 ext bit0 alone", 1'b0, 9'h000);
  endtask

  task automatic t_mask();
    int_en = 1'b1; ext_level = 16'h0208; cur_pil = 4'd9; tick();
    expect_out("R6 mask at 9", 1'b0, 9'h000);
    cur_pil = 4'd8; tick();
    expect_out("R6 mask at 8", 1'b1, 9'h049);
    cur_pil = 4'd15; ext_level = 16'hFFFF; tick();
    expect_out("R6 mask at 15", 1'b0, 9'h000);
    cur_pil = 4'd0; ext_level = '0; tick();
  endtask

  task automatic t_disable();
    int_en = 1'b1; ext_level = 16'h0020; tick();
    expect_out("R7 before", 1'b1, 9'h045);
    int_en = 1'b0; tick();
    expect_out("R7 disabled", 1'b0, 9'h000);
    int_en = 1'b1; tick();
    expect_out("R7 reenabled", 1'b1, 9'h045);
  endtask

  task automatic t_vectored();
    int_en = 1'b1; ext_level = 16'h0020; tick();
    vec_pending = 1'b1; ext_level = 16'h1020; tick();
    expect_out("R8 hold higher", 1'b1, 9'h045);
    int_en = 1'b0; tick();
    expect_out("R8 hold disabled", 1'b1, 9'h045);
    vec_pending = 1'b0; int_en = 1'b1; tick();
    expect_out("R8 released", 1'b1, 9'h04C);
    ext_level = '0; tick();
  endtask

  task automatic t_software();
    int_en = 1'b1; ext_level = '0; cur_pil = 4'd0;
    sw_do(2'b11, 17'h00008);
    chk("R2 load sw", 32'(sw_value), 32'h00008);
    expect_out("R3 sw level3", 1'b1, 9'h043);
    sw_do(2'b01, 17'h00400);
    chk("R2 or sw", 32'(sw_value), 32'h00408);
    expect_out("R3 sw level10", 1'b1, 9'h04A);
    sw_do(2'b10, 17'h00400);
    chk("R2 clear sw", 32'(sw_value), 32'h00008);
    expect_out("R3 sw back to 3", 1'b1, 9'h043);
    sw_op = 2'b00; sw_data = 17'h1FFFF; tick();
    chk("R2 hold sw", 32'(sw_value), 32'h00008);
    sw_do(2'b11, 17'h00001);
    expect_out("R4 tick bit", 1'b1, 9'h04E);
    sw_do(2'b11, 17'h10000);
    expect_out("R4 stick bit", 1'b1, 9'h04E);
    sw_do(2'b11, 17'h00000);
    expect_out("R2 cleared", 1'b0, 9'h000);
  endtask

  task automatic t_suppress();
    int_en = 1'b1; cur_pil = 4'd0; trap_lvl = '0; trap_tt_cur = '0;
    ext_level = 16'h0020; tick();
    expect_out("R9 setup", 1'b1, 9'h045);
    trap_lvl = 3'd1; trap_tt_cur = 9'h04A; ext_level = 16'h00A0; tick();
    expect_out("R9 suppressed", 1'b1, 9'h045);
    ext_level = 16'h10A0; tick();
    expect_out("R9 higher passes", 1'b1, 9'h04C);
    trap_lvl = '0; ext_level = 16'h00A0; tick();
    expect_out("R10 trap level 0", 1'b1, 9'h047);
    trap_lvl = 3'd1; trap_tt_cur = 9'h06A; ext_level = 16'h0020; tick();
    expect_out("R10 outside group", 1'b1, 9'h045);
    trap_lvl = '0; trap_tt_cur = '0; ext_level = '0; tick();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_external();
    t_mask();
    t_disable();
    t_vectored();
    t_software();
    t_suppress();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule